// File: doc/BRIEF.md
# Alternating dual-channel SPI ADC reader

This block is an SPI master that polls a two-channel 12-bit serial converter at a fixed rate. The converter moves to the other input on its own after every conversion, so no channel address is ever sent. The reader opens a frame by pulling chip select low, clocks in sixteen bits on a divided serial clock and then closes the frame. It follows the converter's alternation with a single select bit and sends each result to the output port of the channel it came from.

A conversion timer restarts a frame every `CONV_PERIOD` system clocks. The serial clock has a half period of `SCLK_HALF` system clocks. With a 100 MHz system clock, a half period of 5 gives a 10 MHz serial clock, and a period of 500 gives 200 kSPS in total, which is 100 kSPS on each channel. Each result appears with a valid strobe one cycle long and stays on its port until the next frame for that channel.

Top module: `alt_adc_reader`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the cycle after it is released, chip select is high, the serial clock is high and both valid strobes are low. The first frame after reset is delivered to channel 0.
- R2: A frame starts every `CONV_PERIOD` system clocks, so each channel's valid strobe repeats exactly every 2×`CONV_PERIOD` clocks.
- R3: While chip select is low, each low phase of the serial clock lasts exactly `SCLK_HALF` system clocks. While chip select is high, the serial clock is high.
- R4: Each chip-select-low window contains exactly 16 rising edges of the serial clock, and chip select then returns high.
- R5: MISO is sampled on each rising edge of the serial clock with the first bit as MSB, and the last 12 bits sampled form the result.
- R6: The first four bits of a frame are not part of the result, whatever their value.
- R7: Frames go to channel 0 and channel 1 in strict alternation, and each channel's result appears only on that channel's data port.
- R8: Each valid strobe lasts exactly one system clock, and the two strobes are never high in the same cycle.
- R9: A channel's data output keeps its value between that channel's valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_miso | input | 1 | Serial data from the converter |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, high when idle |
| res0_data | output | 12 | Latest channel 0 result |
| res0_valid | output | 1 | One-cycle strobe for a new channel 0 result |
| res1_data | output | 12 | Latest channel 1 result |
| res1_valid | output | 1 | One-cycle strobe for a new channel 1 result |

## Verification
The bench builds the reader with `SCLK_HALF` = 2 and `CONV_PERIOD` = 80. At these values a frame takes less than a period, and several hundred frames fit in a short run. Over those frames the converter model steps the channel 0 code through multiples of 273 from 0 to 4095, and channel 1 receives the complement of each code, so both extreme codes and many bit patterns reach each port. The model fills the leading four bits of the frame with 0, 0xF and 0x5 in turn, so any leak of those bits into a result is detected. A reset in the middle of a frame shows that the alternation starts again at channel 0.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SHIFT = 2'd1,
        RD_CLOSE = 2'd2
    } rd_state_e;

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CONV_PERIOD = 500
) (
    input  logic clk,
    input  logic rst,
    output logic start_o
);
    localparam int CW = (CONV_PERIOD > 2) ? $clog2(CONV_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          start;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        d.start = (q.cnt == LAST);
        if (q.cnt == LAST) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign start_o = q.start;

    // R2: consecutive start pulses never arrive back to back
    a_r2_start_spacing: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int SCLK_HALF = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o
);
    localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } sck_t;

    sck_t d, q;
    logic toggle;

    always_comb begin
        d = q;
        toggle = run_i && (q.cnt == LAST);
        if (!run_i) begin
            d.cnt  = '0;
            d.sclk = 1'b1;
        end else if (toggle) begin
            d.cnt  = '0;
            d.sclk = ~q.sclk;
        end else begin
            d.cnt  = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{cnt: '0, sclk: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign rise_o = toggle && !q.sclk;

    // R3: once stopped, the serial clock is high from the next cycle
    a_r3_stop_high: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> sclk_o);

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
    import adc_rd_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int DATA_BITS  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 rise_i,
    input  logic                 miso_i,
    output logic                 run_o,
    output logic                 cs_n_o,
    output logic [DATA_BITS-1:0] ch0_data_o,
    output logic                 ch0_valid_o,
    output logic [DATA_BITS-1:0] ch1_data_o,
    output logic                 ch1_valid_o
);
    localparam int BCW = $clog2(FRAME_BITS + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);
    localparam logic [BCW-1:0] ALL_BITS = BCW'(FRAME_BITS);

    typedef struct packed {
        rd_state_e            st;
        logic [DATA_BITS-1:0] sh;
        logic [BCW-1:0]       bits;
        logic                 sel;
        logic                 cs_n;
        logic [DATA_BITS-1:0] d0;
        logic                 v0;
        logic [DATA_BITS-1:0] d1;
        logic                 v1;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        d.v0 = 1'b0;
        d.v1 = 1'b0;
        unique case (q.st)
            RD_IDLE: begin
                if (start_i) begin
                    d.st   = RD_SHIFT;
                    d.cs_n = 1'b0;
                    d.bits = '0;
                end
            end
            RD_SHIFT: begin
                if (rise_i) begin
                    // a short register drops the leading bits as they pass
                    d.sh   = {q.sh[DATA_BITS-2:0], miso_i};
                    d.bits = q.bits + 1'b1;
                    if (q.bits == LAST_BIT) begin
                        d.st = RD_CLOSE;
                    end
                end
            end
            RD_CLOSE: begin
                d.cs_n = 1'b1;
                if (q.sel) begin
                    d.d1 = q.sh;
                    d.v1 = 1'b1;
                end else begin
                    d.d0 = q.sh;
                    d.v0 = 1'b1;
                end
                d.sel = ~q.sel;
                d.st  = RD_IDLE;
            end
            default: begin
                d.st   = RD_IDLE;
                d.cs_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: RD_IDLE, sh: '0, bits: '0, sel: 1'b0, cs_n: 1'b1,
                   d0: '0, v0: 1'b0, d1: '0, v1: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign run_o       = (q.st == RD_SHIFT);
    assign cs_n_o      = q.cs_n;
    assign ch0_data_o  = q.d0;
    assign ch0_valid_o = q.v0;
    assign ch1_data_o  = q.d1;
    assign ch1_valid_o = q.v1;

    // R4: the rising-edge count of a frame never passes the frame length
    a_r4_bit_bound: assert property (@(posedge clk) disable iff (rst)
        q.bits <= ALL_BITS);

    // R8: each strobe is a single cycle
    a_r8_pulse0: assert property (@(posedge clk) disable iff (rst)
        ch0_valid_o |=> !ch0_valid_o);
    a_r8_pulse1: assert property (@(posedge clk) disable iff (rst)
        ch1_valid_o |=> !ch1_valid_o);

    // R9: results hold between strobes
    a_r9_hold0: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ch0_valid_o || $stable(ch0_data_o)));
    a_r9_hold1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ch1_valid_o || $stable(ch1_data_o)));

    // R7: a channel 0 strobe is followed by a channel 1 strobe before the next channel 0 one
    a_r7_alternate: assert property (@(posedge clk) disable iff (rst)
        ch0_valid_o |-> q.sel);

endmodule

// File: rtl/alt_adc_reader.sv
module alt_adc_reader #(
    parameter int SCLK_HALF   = 5,
    parameter int CONV_PERIOD = 500,
    parameter int FRAME_BITS  = 16,
    parameter int DATA_BITS   = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_miso,
    output logic                 spi_cs_n,
    output logic                 spi_sclk,
    output logic [DATA_BITS-1:0] res0_data,
    output logic                 res0_valid,
    output logic [DATA_BITS-1:0] res1_data,
    output logic                 res1_valid
);
    logic start;
    logic run;
    logic rise;

    adc_conv_timer #(
        .CONV_PERIOD(CONV_PERIOD)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .start_o (start)
    );

    adc_sclk_gen #(
        .SCLK_HALF(SCLK_HALF)
    ) i_sclk (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .sclk_o (spi_sclk),
        .rise_o (rise)
    );

    adc_frame_fsm #(
        .FRAME_BITS(FRAME_BITS),
        .DATA_BITS (DATA_BITS)
    ) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .rise_i      (rise),
        .miso_i      (spi_miso),
        .run_o       (run),
        .cs_n_o      (spi_cs_n),
        .ch0_data_o  (res0_data),
        .ch0_valid_o (res0_valid),
        .ch1_data_o  (res1_data),
        .ch1_valid_o (res1_valid)
    );

    // R3: the serial clock is high whenever chip select is high
    a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> spi_sclk);

    // R2: a new conversion is only requested while no frame is open
    a_r2_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> (spi_cs_n && !run));

    // R8: the two strobes are never high in the same cycle
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res0_valid, res1_valid}));

endmodule

// File: tb/test_alt_adc_reader.sv
module test_alt_adc_reader;
    localparam int HALF = 2;
    localparam int PER  = 80;
    localparam int DW   = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_miso = 1'b0;
    logic spi_cs_n, spi_sclk, res0_valid, res1_valid;
    logic [DW-1:0] res0_data, res1_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alt_adc_reader #(
        .SCLK_HALF  (HALF),
        .CONV_PERIOD(PER),
        .FRAME_BITS (16),
        .DATA_BITS  (DW)
    ) i_alt_adc_reader (
        .clk       (clk),
        .rst       (rst),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .res0_data (res0_data),
        .res0_valid(res0_valid),
        .res1_data (res1_data),
        .res1_valid(res1_valid)
    );

    function automatic logic [11:0] exp_code(int ch, int k);
        logic [11:0] c0;
        c0 = 12'((k * 273) % 4096);
        return (ch == 0) ? c0 : 12'(4095 - int'(c0));
    endfunction

    function automatic logic [3:0] lead_bits(int k);
        return (k % 3 == 0) ? 4'h0 : ((k % 3 == 1) ? 4'hF : 4'h5);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // converter model: alternates channels by itself, shifts on falling edges
    int frame_no = 0;
    logic [15:0] cur_frame = '0;
    int idx = 0;

    initial forever begin
        @(negedge spi_cs_n);
        if (!rst) begin
            cur_frame = {lead_bits(frame_no / 2), exp_code(frame_no % 2, frame_no / 2)};
            frame_no++;
            idx = 16;
        end
    end

    initial forever begin
        @(negedge spi_sclk);
        if (!spi_cs_n && idx > 0) begin
            idx--;
            spi_miso = cur_frame[idx];
        end
    end

    // output monitor
    int n0 = 0, n1 = 0, cyc = 0, last0 = 0, last1 = 0;
    int rises = 0, lowlen = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_v0 = 1'b0, prev_v1 = 1'b0;
    logic [DW-1:0] held0 = '0, held1 = '0;

    initial forever begin
        @(negedge clk);
        if (rst) begin
            n0 = 0; n1 = 0; rises = 0; lowlen = 0;
            prev_cs = 1'b1; prev_sclk = 1'b1; prev_v0 = 1'b0; prev_v1 = 1'b0;
            held0 = '0; held1 = '0;
        end else begin
            cyc++;
            if (res0_valid && res1_valid)
                check(1'b0, "R8", "both strobes high", 1, 0);
            if (res0_valid && prev_v0) check(1'b0, "R8", "ch0 strobe width", 2, 1);
            if (res1_valid && prev_v1) check(1'b0, "R8", "ch1 strobe width", 2, 1);
            if (!res0_valid && res0_data != held0)
                check(1'b0, "R9", "ch0 hold", int'(res0_data), int'(held0));
            if (!res1_valid && res1_data != held1)
                check(1'b0, "R9", "ch1 hold", int'(res1_data), int'(held1));
            if (res0_valid) begin
                // R5 R6: result is the low 12 bits, whatever the leading four were
                check(res0_data == exp_code(0, n0),
                      (lead_bits(n0) != 0) ? "R6" : "R5", "ch0 data",
                      int'(res0_data), int'(exp_code(0, n0)));
                check(n0 == n1, (n0 == 0) ? "R1" : "R7", "ch0 order", n0, n1);
                if (n0 > 0) check(cyc - last0 == 2 * PER, "R2", "ch0 interval",
                                  cyc - last0, 2 * PER);
                last0 = cyc; held0 = res0_data; n0++;
            end
            if (res1_valid) begin
                check(res1_data == exp_code(1, n1),
                      (lead_bits(n1) != 0) ? "R6" : "R5", "ch1 data",
                      int'(res1_data), int'(exp_code(1, n1)));
                check(n1 == n0 - 1, "R7", "ch1 order", n1, n0 - 1);
                if (n1 > 0) check(cyc - last1 == 2 * PER, "R2", "ch1 interval",
                                  cyc - last1, 2 * PER);
                last1 = cyc; held1 = res1_data; n1++;
            end
            if (spi_cs_n && !spi_sclk) check(1'b0, "R3", "sclk low with cs high", 0, 1);
            if (!spi_sclk) lowlen++;
            if (spi_sclk && !prev_sclk) begin
                check(lowlen == HALF, "R3", "sclk low phase", lowlen, HALF);
                lowlen = 0;
                if (!spi_cs_n) rises++;
            end
            if (spi_cs_n && !prev_cs) begin
                check(rises == 16, "R4", "rising edges per frame", rises, 16);
                rises = 0;
            end
            prev_cs = spi_cs_n; prev_sclk = spi_sclk;
            prev_v0 = res0_valid; prev_v1 = res1_valid;
        end
    end

    task automatic check_idle(input string what);
        check(spi_cs_n == 1'b1, "R1", {what, " cs"}, int'(spi_cs_n), 1);
        check(spi_sclk == 1'b1, "R1", {what, " sclk"}, int'(spi_sclk), 1);
        check(!res0_valid && !res1_valid, "R1", {what, " strobes"},
              int'({res0_valid, res1_valid}), 0);
    endtask

    initial begin
        #1500000;
        check(1'b0, "R2", "watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        frame_no = 0;
        repeat (5) @(negedge clk);
        check_idle("in reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("after reset");
        while (n0 < 150 || n1 < 150) @(negedge clk);
        // reset in the middle of a frame
        while (spi_cs_n) @(negedge clk);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        frame_no = 0;
        repeat (2) @(negedge clk);
        check_idle("mid-frame reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("after second reset");
        while (n0 < 20 || n1 < 20) @(negedge clk);
        check(n0 >= 20 && n1 >= 20, "R1", "frames after reset", n0, 20);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule